// File: doc/BRIEF.md
# Age-Ordered Issue Scheduler Queue

This block is a small scheduling queue placed in front of one execution port. Micro-ops enter through an allocate stream. Each carries two source operand tags, each with a ready flag, and a destination tag. While a micro-op waits in the queue, the block watches a result-broadcast bus. Any waiting source whose tag equals the broadcast tag is marked ready. Each cycle the block offers the port the oldest resident micro-op whose two sources are both ready. Age is the order of allocation. Entries that are older but still waiting are passed over. When the port accepts the offer, the entry leaves the queue and its slot can be used again.

Both data interfaces use valid/ready. On the allocate side, a micro-op is taken on a cycle where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` falls when all slots are occupied, unless the port accepts an issue in that same cycle. In that case the freed slot takes the new micro-op at once. On the issue side, an offered micro-op stays in the queue for as long as `iss_ready` is low. A synchronous flush empties the queue in one cycle. Each execution port gets its own instance of the block.

A source that a micro-op does not use is allocated with its ready flag set.

Top module: `rs_sched`

## Requirements
- R1: After reset the queue is empty: `iss_valid` is 0, `full` is 0 and `alloc_ready` is 1.
- R2: At most one micro-op is offered per cycle. It is always the oldest, by allocation order, of the entries whose two source ready flags are both 1.
- R3: An older entry that is still waiting on a source is skipped, and a younger ready entry is offered in its place.
- R4: When no resident entry has both sources ready, `iss_valid` is 0.
- R5: When `wk_valid` is 1, every source (resident, or being allocated in that cycle) whose tag equals `wk_tag` becomes ready. An entry completed this way is offered no earlier than the next cycle.
- R6: `full` is 1 exactly when all DEPTH slots are occupied. While full, `alloc_ready` is 0 unless an issue is accepted in the same cycle, in which case the new micro-op is taken into the freed slot.
- R7: A micro-op that is allocated with both sources ready is offered no earlier than the cycle after its allocation.
- R8: When `flush` is 1, `iss_valid` and `alloc_ready` are 0, and every entry is removed at that clock edge. Later broadcasts cannot revive a flushed entry.
- R9: While `iss_valid` is 1 and `iss_ready` is 0, the offered entry stays resident and is offered again on a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of every entry |
| alloc_valid | input | 1 | Allocate stream: a micro-op is presented |
| alloc_ready | output | 1 | Allocate stream: queue can take it this cycle |
| alloc_src0 | input | RS_TAG_W | First source tag |
| alloc_src0_rdy | input | 1 | First source already available |
| alloc_src1 | input | RS_TAG_W | Second source tag |
| alloc_src1_rdy | input | 1 | Second source already available |
| alloc_dst | input | RS_TAG_W | Destination tag |
| wk_valid | input | 1 | Result broadcast valid |
| wk_tag | input | RS_TAG_W | Result broadcast tag |
| iss_valid | output | 1 | Issue stream: a micro-op is offered |
| iss_ready | input | 1 | Issue stream: port accepts the offer |
| iss_dst | output | RS_TAG_W | Destination tag of the offered micro-op |
| full | output | 1 | All slots occupied |

## Verification
The hardest situation to reach from the ports is a full queue in which an issue is accepted and a new micro-op arrives in the same cycle. This needs eight resident entries that are all waiting, then one well-timed broadcast, then the port's accept and an allocation on one clock. Directed sequences fill the queue with entries that each wait on a distinct tag, wake exactly one of them, and raise `iss_ready` together with `alloc_valid`. A random phase follows. It draws source tags and broadcast tags from a pool of only eight values, so wake-ups that coincide with allocation, with each other and with issue stalls happen often. A bench model that tracks age by allocation sequence number checks every cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;
  parameter int unsigned RS_TAG_W = 6;
  typedef logic [RS_TAG_W-1:0] tag_t;
endpackage

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic alloc_en,
  input  tag_t in_src0,
  input  logic in_src0_rdy,
  input  tag_t in_src1,
  input  logic in_src1_rdy,
  input  tag_t in_dst,
  input  logic clr,
  input  logic wk_valid,
  input  tag_t wk_tag,
  output logic valid_o,
  output logic ready_o,
  output tag_t dst_o
);
  logic vld_q, r0_q, r1_q;
  tag_t s0_q, s1_q, dst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      r0_q  <= 1'b0;
      r1_q  <= 1'b0;
      s0_q  <= '0;
      s1_q  <= '0;
      dst_q <= '0;
    end else if (flush) begin
      vld_q <= 1'b0;
    end else if (alloc_en) begin
      vld_q <= 1'b1;
      s0_q  <= in_src0;
      s1_q  <= in_src1;
      dst_q <= in_dst;
      r0_q  <= in_src0_rdy | (wk_valid && wk_tag == in_src0);
      r1_q  <= in_src1_rdy | (wk_valid && wk_tag == in_src1);
    end else begin
      if (clr) vld_q <= 1'b0;
      if (vld_q && wk_valid && wk_tag == s0_q) r0_q <= 1'b1;
      if (vld_q && wk_valid && wk_tag == s1_q) r1_q <= 1'b1;
    end
  end

  assign valid_o = vld_q;
  assign ready_o = vld_q & r0_q & r1_q;
  assign dst_o   = dst_q;

  AST_WAKE_SRC0: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !clr && !flush && !alloc_en && wk_valid && wk_tag == s0_q) |=> r0_q); // R5
  AST_WAKE_SRC1: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !clr && !flush && !alloc_en && wk_valid && wk_tag == s1_q) |=> r1_q); // R5
endmodule

// File: rtl/rs_age_matrix.sv
module rs_age_matrix #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] valid,
  input  logic [N-1:0] live,
  input  logic [N-1:0] alloc_oh,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  localparam logic [N-1:0] UNIT = N'(1);

  // older_q[i][j] set: entry j was allocated before entry i
  logic [N-1:0] older_q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (alloc_oh[i]) older_q[i] <= live & ~(UNIT << i);
        else             older_q[i] <= older_q[i] & ~alloc_oh;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) grant[i] = req[i] & ~(|(older_q[i] & req));
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gj = 0; gj < N; gj++) begin : g_col
      if (gi != gj) begin : g_pair
        AST_AGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
          (valid[gi] && valid[gj]) |-> !(older_q[gi][gj] && older_q[gj][gi])); // R2
      end
    end
  end
endmodule

// File: rtl/rs_sched.sv
module rs_sched
  import rs_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                alloc_valid,
  output logic                alloc_ready,
  input  logic [RS_TAG_W-1:0] alloc_src0,
  input  logic                alloc_src0_rdy,
  input  logic [RS_TAG_W-1:0] alloc_src1,
  input  logic                alloc_src1_rdy,
  input  logic [RS_TAG_W-1:0] alloc_dst,
  input  logic                wk_valid,
  input  logic [RS_TAG_W-1:0] wk_tag,
  output logic                iss_valid,
  input  logic                iss_ready,
  output logic [RS_TAG_W-1:0] iss_dst,
  output logic                full
);
  logic [DEPTH-1:0] valid, rdy, grant, clr, free, pick, alloc_oh, live;
  tag_t             ent_dst [DEPTH];
  logic             fire;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    rs_entry u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .alloc_en   (alloc_oh[g]),
      .in_src0    (alloc_src0),
      .in_src0_rdy(alloc_src0_rdy),
      .in_src1    (alloc_src1),
      .in_src1_rdy(alloc_src1_rdy),
      .in_dst     (alloc_dst),
      .clr        (clr[g]),
      .wk_valid   (wk_valid),
      .wk_tag     (wk_tag),
      .valid_o    (valid[g]),
      .ready_o    (rdy[g]),
      .dst_o      (ent_dst[g])
    );
  end

  rs_age_matrix #(.N(DEPTH)) u_age (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (valid),
    .live    (live),
    .alloc_oh(alloc_oh),
    .req     (rdy),
    .grant   (grant)
  );

  assign iss_valid = (|grant) & ~flush;
  assign fire      = iss_valid & iss_ready;
  assign clr       = fire ? grant : '0;
  assign live      = valid & ~clr;
  assign free      = ~live;
  assign pick      = free & (~free + 1'b1);
  assign alloc_ready = (|free) & ~flush;
  assign alloc_oh  = (alloc_valid && alloc_ready) ? pick : '0;
  assign full      = &valid;

  always_comb begin
    iss_dst = '0;
    for (int i = 0; i < DEPTH; i++) if (grant[i]) iss_dst = iss_dst | ent_dst[i];
  end

  AST_NO_IDLE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|rdy) |-> !iss_valid); // R4
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !fire) |-> !alloc_ready); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid == '0)); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> |(valid & $past(grant))); // R9
endmodule

// File: tb/rs_sched_tb.sv
`timescale 1ns/1ps
module rs_sched_tb;
  import rs_pkg::*;
  localparam int D = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, alloc_valid = 0, a_r0 = 0, a_r1 = 0, wk_valid = 0, iss_ready = 0;
  tag_t a_s0 = '0, a_s1 = '0, a_dst = '0, wk_tag = '0;
  logic alloc_ready, iss_valid, full;
  tag_t iss_dst;

  always #4 clk = ~clk;

  rs_sched #(.DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_src0(a_s0), .alloc_src0_rdy(a_r0), .alloc_src1(a_s1), .alloc_src1_rdy(a_r1),
    .alloc_dst(a_dst), .wk_valid(wk_valid), .wk_tag(wk_tag), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .iss_dst(iss_dst), .full(full)
  );

  int checks = 0, fails = 0;
  int m_v [D], m_r0 [D], m_r1 [D], m_seq [D];
  tag_t m_s0 [D], m_s1 [D], m_dst [D];
  int m_cnt = 0, seq_n = 0, dst_n = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int m_pick();
    int best = -1;
    for (int i = 0; i < D; i++)
      if (m_v[i] != 0 && m_r0[i] != 0 && m_r1[i] != 0 && (best < 0 || m_seq[i] < m_seq[best])) best = i;
    return best;
  endfunction

  // one clock: inputs already driven; compare, then advance model at the edge
  task automatic step(string req);
    int p, e_iv, e_ar;
    #1;
    p    = m_pick();
    e_iv = (p >= 0 && !flush) ? 1 : 0;
    e_ar = (!flush && (m_cnt < D || (e_iv != 0 && iss_ready))) ? 1 : 0;
    chk(req, "iss_valid", int'(iss_valid), e_iv);
    if (e_iv != 0) chk(req, "iss_dst", int'(iss_dst), int'(m_dst[p]));
    chk("R6", "full", int'(full), (m_cnt == D) ? 1 : 0);
    chk("R6", "alloc_ready", int'(alloc_ready), e_ar);
    @(posedge clk);
    if (flush) begin
      for (int i = 0; i < D; i++) m_v[i] = 0;
      m_cnt = 0;
    end else begin
      if (e_iv != 0 && iss_ready) begin m_v[p] = 0; m_cnt--; end
      for (int i = 0; i < D; i++) if (m_v[i] != 0 && wk_valid) begin
        if (m_s0[i] == wk_tag) m_r0[i] = 1;
        if (m_s1[i] == wk_tag) m_r1[i] = 1;
      end
      if (alloc_valid && e_ar != 0) begin
        for (int k = 0; k < D; k++) if (m_v[k] == 0) begin
          m_v[k] = 1; m_s0[k] = a_s0; m_s1[k] = a_s1; m_dst[k] = a_dst;
          m_r0[k] = (a_r0 || (wk_valid && wk_tag == a_s0)) ? 1 : 0;
          m_r1[k] = (a_r1 || (wk_valid && wk_tag == a_s1)) ? 1 : 0;
          m_seq[k] = seq_n++; m_cnt++;
          break;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic set_alloc(int s0, int r0, int s1, int r1);
    alloc_valid = 1; a_s0 = tag_t'(s0); a_r0 = r0[0]; a_s1 = tag_t'(s1); a_r1 = r1[0];
    a_dst = tag_t'(dst_n); dst_n++;
  endtask

  task automatic idle();
    alloc_valid = 0; wk_valid = 0; flush = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < D; i++) m_v[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk("R1", "iss_valid", int'(iss_valid), 0);
    chk("R1", "full", int'(full), 0);
    chk("R1", "alloc_ready", int'(alloc_ready), 1);

    // R7: ready-on-arrival micro-op waits one cycle
    iss_ready = 1; set_alloc(1, 1, 2, 1); step("R7");
    idle(); step("R7");

    // R3: oldest waits on tag 5, younger ready ones pass it
    iss_ready = 0;
    set_alloc(5, 0, 3, 1); step("R3");
    set_alloc(3, 1, 4, 1); step("R3");
    set_alloc(6, 1, 7, 1); step("R3");
    idle(); iss_ready = 1;
    step("R3"); step("R3"); step("R4");

    // R5: broadcast completes the oldest, offered next cycle
    wk_valid = 1; wk_tag = 5; step("R5");
    idle(); step("R5"); step("R4");

    // R4/R6: fill with eight waiting entries
    for (int i = 0; i < D; i++) begin set_alloc(16 + i, 0, 40, 1); step("R4"); end
    idle(); step("R4");
    set_alloc(33, 1, 34, 1); step("R6");          // refused while full
    alloc_valid = 0; wk_valid = 1; wk_tag = 16; step("R6");
    wk_valid = 0; set_alloc(30, 0, 40, 1); step("R6"); // issue and refill together
    idle(); step("R6");

    // R9: stall holds the offered entry
    iss_ready = 0; wk_valid = 1; wk_tag = 17; step("R9");
    wk_valid = 0; step("R9"); step("R9"); step("R9");
    iss_ready = 1; step("R9"); step("R4");

    // R8: flush, with an allocation attempt, then no revival
    flush = 1; set_alloc(9, 1, 9, 1); step("R8");
    idle(); step("R8");
    wk_valid = 1; wk_tag = 18; step("R8");
    idle(); step("R8");

    // random mix
    for (int c = 0; c < 4000; c++) begin
      flush       = ($urandom % 64) == 0;
      wk_valid    = $urandom % 2;
      wk_tag      = tag_t'($urandom % 8);
      iss_ready   = ($urandom % 4) != 0;
      if ($urandom % 2) set_alloc($urandom % 8, (($urandom % 3) == 0) ? 1 : 0,
                                  $urandom % 8, (($urandom % 3) == 0) ? 1 : 0);
      else alloc_valid = 0;
      step("R2");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule